// File: doc/BRIEF.md
# Banked Chained Hash Dictionary

This block is the history store of a parallel LZ77 compressor. In every cycle it takes a window of VEC substrings, each VEC bytes long. Each substring arrives with a bank number and an address inside that bank, both produced by an external hash stage. The store holds 2×VEC banks on the single system clock. Each bank is a chain of DEPTH memories. A lookup returns, for every substring, one stored candidate from every depth of the chain, so a later match stage can compare the substring against several earlier strings that share its hash.

Each stored entry is a VEC-byte string plus its absolute byte position. Substring i of a window stores the position `in_pos + i`. When a substring wins its bank, the new entry goes into depth 1 at that address. The entry that was at depth k moves to depth k+1, and the entry at the deepest level is dropped. When several substrings of one window name the same bank, the lowest-index substring takes it. The others get no candidates and write nothing, so downstream logic emits them as literals. Results appear one cycle after the request, together with a delayed copy of the window and its base position.

Top module: `chained_hash_dict`

## Requirements
- R1: There are 2×VEC banks, numbered by `in_bank` (one field of clog2(2×VEC) bits per substring, substring i at bits [i*BW +: BW]). In a valid window, every substring whose bank is unused by any lower-index substring gets `out_hit[i]`=1.
- R2: When substrings of one window share a bank, only the lowest-index one gets `out_hit`=1. The others get `out_hit`=0, `cand_vld`=0, and zero candidate string and position at every depth.
- R3: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid`=1, and 0 otherwise. `out_str` and `out_pos` then repeat that window's `in_str` and `in_pos`.
- R4: For a granted substring, depth 1 returns the entry most recently written to the same bank and address. Each written entry is the substring (substring i at `in_str[i*VEC*8 +: VEC*8]`) with position `in_pos + i`, modulo 2^POS_W.
- R5: Each write moves the old depth-k entry at that address to depth k+1 and drops the old deepest entry. Depth k+1 of the output (at `cand_*[(k*VEC+i)*width +: width]`) therefore returns the entry written k+1 writes earlier.
- R6: A synchronous active-low reset invalidates every stored entry and clears `out_valid` and `out_hit`. Until an address is written again, lookups of it give `cand_vld`=0.
- R7: A substring that loses its bank, and any window with `in_valid`=0, leaves all stored entries unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Window present this cycle |
| in_str | input | VEC*VEC*8 | VEC substrings, substring i at [i*VEC*8 +: VEC*8] |
| in_bank | input | VEC*clog2(2*VEC) | Bank number per substring |
| in_addr | input | VEC*AW | Address inside the bank per substring |
| in_pos | input | POS_W | Absolute byte position of substring 0 |
| out_valid | output | 1 | Results of the previous window present |
| out_str | output | VEC*VEC*8 | Delayed window substrings |
| out_pos | output | POS_W | Delayed window base position |
| out_hit | output | VEC | Per substring: bank access granted |
| cand_str | output | DEPTH*VEC*VEC*8 | Candidate string per depth and substring |
| cand_pos | output | DEPTH*VEC*POS_W | Candidate position per depth and substring |
| cand_vld | output | DEPTH*VEC | Candidate holds a written entry |

## Verification
In one cycle the same bank can be read for a granted substring and also contested by losing substrings whose own addresses must stay untouched. Arbitration and the chain write therefore meet in a single edge. The bench provokes this with windows where every substring, or a middle pair, names one bank with distinct addresses. It then reads the losers' addresses in later windows and expects them to be invalid. Each window is judged against a reference dictionary kept in the bench, which checks the grant pattern, the returned depth-ordered candidates and the delayed window.

// File: rtl/hdict_pkg.sv
// Shared constants for the chained hash dictionary.
// Assumes VEC is a power of two no larger than 16, so that the
// write steering fits a two-level radix-4 multiplexer tree.
package hdict_pkg;
    localparam int unsigned MUX_RADIX  = 4;
    localparam int unsigned MUX_LEVELS = 2;
    localparam int unsigned MUX_INPUTS = MUX_RADIX ** MUX_LEVELS;
    localparam int unsigned BYTE_W     = 8;
endpackage

// File: rtl/hdict_arbiter.sv
// Bank arbiter: for each bank, picks the lowest-index substring that
// names it; for each substring, reports whether it won its bank.
// Purely combinational; clock and reset only serve the assertions.
module hdict_arbiter #(
    parameter int VEC   = 4,
    parameter int NBANK = 8,
    parameter int BI_W  = 3,
    parameter int SEL_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [VEC*BI_W-1:0]    bank_idx,
    output logic [NBANK*SEL_W-1:0] gnt_sel,
    output logic [NBANK-1:0]       gnt_any,
    output logic [VEC-1:0]         sub_hit
);
    // per-bank winner: scan downward so the lowest index is written last
    always_comb begin
        for (int b = 0; b < NBANK; b++) begin
            gnt_any[b] = 1'b0;
            gnt_sel[b*SEL_W +: SEL_W] = '0;
            for (int i = VEC - 1; i >= 0; i--) begin
                if (req_valid && bank_idx[i*BI_W +: BI_W] == BI_W'(b)) begin
                    gnt_any[b] = 1'b1;
                    gnt_sel[b*SEL_W +: SEL_W] = SEL_W'(i);
                end
            end
        end
    end

    // per-substring outcome: lost if any lower index shares the bank
    always_comb begin
        for (int i = 0; i < VEC; i++) begin
            sub_hit[i] = req_valid;
            for (int j = 0; j < i; j++) begin
                if (bank_idx[j*BI_W +: BI_W] == bank_idx[i*BI_W +: BI_W])
                    sub_hit[i] = 1'b0;
            end
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < VEC; gi++) begin : g_chk
            // R1: a winning substring must be the one selected for its bank
            p_hit_owns_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
                sub_hit[gi] |-> (gnt_any[bank_idx[gi*BI_W +: BI_W]] &&
                    gnt_sel[bank_idx[gi*BI_W +: BI_W]*SEL_W +: SEL_W] == SEL_W'(gi)));
        end
    endgenerate
endmodule

// File: rtl/hdict_mux4_tree.sv
// Write-side steering: selects one of N inputs through two levels of
// 4-to-1 multiplexers (low select pair first, then high pair).
// Assumes N <= 16 and SEL_W <= 4; unused inputs read as zero.
module hdict_mux4_tree #(
    parameter int N     = 4,
    parameter int W     = 8,
    parameter int SEL_W = 2
) (
    input  logic [N*W-1:0]   din,
    input  logic [SEL_W-1:0] sel,
    output logic [W-1:0]     dout
);
    import hdict_pkg::*;
    localparam int NIN = MUX_INPUTS;

    logic [NIN*W-1:0] dpad;
    logic [3:0]       sel4;
    logic [W-1:0]     lvl1 [MUX_RADIX];

    // zero-extend the data and select to the full tree size
    always_comb begin
        dpad = '0;
        dpad[N*W-1:0] = din;
        sel4 = '0;
        sel4[SEL_W-1:0] = sel;
    end

    genvar g;
    generate
        for (g = 0; g < MUX_RADIX; g++) begin : g_lvl1
            // first level: one 4-to-1 per group of four inputs
            always_comb lvl1[g] = dpad[(g*MUX_RADIX + int'(sel4[1:0]))*W +: W];
        end
    endgenerate

    // second level: one 4-to-1 across the group results
    always_comb dout = lvl1[sel4[3:2]];
endmodule

// File: rtl/hdict_bank.sv
// One bank with its full depth chain. On a write, every depth is read
// at the address into registers (one-cycle latency), depth 0 takes the
// new entry and depth k takes the old depth k-1 entry; the deepest old
// entry is lost. Without a write, storage and read registers hold.
module hdict_bank #(
    parameter int DEPTH = 3,
    parameter int AW    = 4,
    parameter int EW    = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [AW-1:0]      addr,
    input  logic [EW-1:0]      wdata,
    output logic [DEPTH*EW-1:0] rd_data,
    output logic [DEPTH-1:0]   rd_vld
);
    localparam int NENT = 1 << AW;

    logic [EW-1:0]   mem  [DEPTH][NENT];
    logic [NENT-1:0] vbit [DEPTH];
    logic [EW-1:0]   rd_q [DEPTH];

    // entry storage and read registers: read all depths, then shift
    always_ff @(posedge clk) begin
        if (we) begin
            for (int k = 0; k < DEPTH; k++) rd_q[k] <= mem[k][addr];
            mem[0][addr] <= wdata;
            for (int k = 1; k < DEPTH; k++) mem[k][addr] <= mem[k-1][addr];
        end
    end

    // valid bits follow the entries through the chain; reset clears them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) vbit[k] <= '0;
            rd_vld <= '0;
        end else if (we) begin
            for (int k = 0; k < DEPTH; k++) rd_vld[k] <= vbit[k][addr];
            vbit[0][addr] <= 1'b1;
            for (int k = 1; k < DEPTH; k++) vbit[k][addr] <= vbit[k-1][addr];
        end
    end

    genvar gk;
    generate
        for (gk = 0; gk < DEPTH; gk++) begin : g_out
            assign rd_data[gk*EW +: EW] = rd_q[gk];
        end
        for (gk = 1; gk < DEPTH; gk++) begin : g_chk
            // R5: an older entry can only exist behind a newer one
            p_chain_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
                rd_vld[gk] |-> rd_vld[gk-1]);
        end
    endgenerate
endmodule

// File: rtl/chained_hash_dict.sv
// Banked, chained hash dictionary for a parallel LZ77 front end.
// Takes VEC substrings per cycle with external bank/address hashes,
// arbitrates 2*VEC banks (lowest index wins), steers each winner into
// its bank chain and returns per-depth candidates one cycle later,
// mapped back to the substrings. Assumes VEC is a power of two <= 16.
module chained_hash_dict #(
    parameter int VEC   = 4,
    parameter int DEPTH = 3,
    parameter int AW    = 4,
    parameter int POS_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [VEC*VEC*8-1:0]          in_str,
    input  logic [VEC*$clog2(2*VEC)-1:0]  in_bank,
    input  logic [VEC*AW-1:0]             in_addr,
    input  logic [POS_W-1:0]              in_pos,
    output logic                          out_valid,
    output logic [VEC*VEC*8-1:0]          out_str,
    output logic [POS_W-1:0]              out_pos,
    output logic [VEC-1:0]                out_hit,
    output logic [DEPTH*VEC*VEC*8-1:0]    cand_str,
    output logic [DEPTH*VEC*POS_W-1:0]    cand_pos,
    output logic [DEPTH*VEC-1:0]          cand_vld
);
    import hdict_pkg::*;
    localparam int NBANK = 2 * VEC;
    localparam int BI_W  = $clog2(NBANK);
    localparam int SEL_W = (VEC > 1) ? $clog2(VEC) : 1;
    localparam int SW    = VEC * BYTE_W;
    localparam int EW    = SW + POS_W;

    logic [NBANK*SEL_W-1:0] gnt_sel;
    logic [NBANK-1:0]       gnt_any;
    logic [VEC-1:0]         sub_hit;
    logic [VEC*EW-1:0]      ents;
    logic [DEPTH*EW-1:0]    brd  [NBANK];
    logic [DEPTH-1:0]       bvld [NBANK];
    logic [VEC*BI_W-1:0]    bank_q;

    hdict_arbiter #(.VEC(VEC), .NBANK(NBANK), .BI_W(BI_W), .SEL_W(SEL_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .req_valid(in_valid), .bank_idx(in_bank),
        .gnt_sel(gnt_sel), .gnt_any(gnt_any), .sub_hit(sub_hit)
    );

    // entry for each substring: {absolute position, string}
    always_comb begin
        for (int i = 0; i < VEC; i++)
            ents[i*EW +: EW] = {in_pos + POS_W'(i), in_str[i*SW +: SW]};
    end

    genvar gb;
    generate
        for (gb = 0; gb < NBANK; gb++) begin : g_bank
            logic [EW-1:0] wdata;
            logic [AW-1:0] waddr;

            hdict_mux4_tree #(.N(VEC), .W(EW), .SEL_W(SEL_W)) u_dmux (
                .din(ents), .sel(gnt_sel[gb*SEL_W +: SEL_W]), .dout(wdata)
            );
            hdict_mux4_tree #(.N(VEC), .W(AW), .SEL_W(SEL_W)) u_amux (
                .din(in_addr), .sel(gnt_sel[gb*SEL_W +: SEL_W]), .dout(waddr)
            );
            hdict_bank #(.DEPTH(DEPTH), .AW(AW), .EW(EW)) u_bank (
                .clk(clk), .rst_n(rst_n), .we(gnt_any[gb]), .addr(waddr),
                .wdata(wdata), .rd_data(brd[gb]), .rd_vld(bvld[gb])
            );
        end
    endgenerate

    // control pipeline: window valid and grant pattern, reset-cleared
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hit   <= '0;
        end else begin
            out_valid <= in_valid;
            out_hit   <= sub_hit;
        end
    end

    // data pipeline: delayed window for the comparison stage
    always_ff @(posedge clk) begin
        out_str <= in_str;
        out_pos <= in_pos;
        bank_q  <= in_bank;
    end

    // map bank read results back to substrings; losers get zeros
    always_comb begin
        for (int k = 0; k < DEPTH; k++) begin
            for (int i = 0; i < VEC; i++) begin
                cand_str[(k*VEC+i)*SW +: SW]       = '0;
                cand_pos[(k*VEC+i)*POS_W +: POS_W] = '0;
                cand_vld[k*VEC+i]                  = 1'b0;
                if (out_hit[i]) begin
                    cand_str[(k*VEC+i)*SW +: SW] =
                        brd[bank_q[i*BI_W +: BI_W]][k*EW +: SW];
                    cand_pos[(k*VEC+i)*POS_W +: POS_W] =
                        brd[bank_q[i*BI_W +: BI_W]][k*EW + SW +: POS_W];
                    cand_vld[k*VEC+i] = bvld[bank_q[i*BI_W +: BI_W]][k];
                end
            end
        end
    end

    // R3: results follow a window by exactly one cycle
    p_result_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R3: no results without a window
    p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R7: idle windows grant nothing
    p_idle_no_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_hit == '0);

    genvar gc;
    generate
        for (gc = 0; gc < DEPTH*VEC; gc++) begin : g_vchk
            // R2: a candidate is only valid for a granted substring
            p_vld_needs_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
                cand_vld[gc] |-> out_hit[gc % VEC]);
        end
    endgenerate
endmodule

// File: tb/sim_chained_hash_dict.sv
// Directed bench for chained_hash_dict with a reference dictionary.
module sim_chained_hash_dict;
    localparam int CLK_PERIOD = 10;
    localparam int VEC = 4, DEPTH = 3, AW = 4, POS_W = 16;
    localparam int NB = 2 * VEC, BW = 3, SW = 32, NENT = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [VEC*SW-1:0] in_str = '0;
    logic [VEC*BW-1:0] in_bank = '0;
    logic [VEC*AW-1:0] in_addr = '0;
    logic [POS_W-1:0]  in_pos = '0;
    logic out_valid;
    logic [VEC*SW-1:0] out_str;
    logic [POS_W-1:0]  out_pos;
    logic [VEC-1:0]    out_hit;
    logic [DEPTH*VEC*SW-1:0]    cand_str;
    logic [DEPTH*VEC*POS_W-1:0] cand_pos;
    logic [DEPTH*VEC-1:0]       cand_vld;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [SW-1:0]    m_str [DEPTH][NB][NENT];
    logic [POS_W-1:0] m_pos [DEPTH][NB][NENT];
    bit               m_v   [DEPTH][NB][NENT];

    chained_hash_dict #(.VEC(VEC), .DEPTH(DEPTH), .AW(AW), .POS_W(POS_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_str(in_str),
        .in_bank(in_bank), .in_addr(in_addr), .in_pos(in_pos),
        .out_valid(out_valid), .out_str(out_str), .out_pos(out_pos),
        .out_hit(out_hit), .cand_str(cand_str), .cand_pos(cand_pos),
        .cand_vld(cand_vld)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] mk(input int seed, input int i);
        return 32'hC0DE_0000 + 32'(seed * 256 + i * 17);
    endfunction

    function automatic logic [VEC*BW-1:0] pk_b(input int a, input int b,
                                               input int c, input int d);
        return {d[BW-1:0], c[BW-1:0], b[BW-1:0], a[BW-1:0]};
    endfunction

    function automatic logic [VEC*AW-1:0] pk_a(input int a, input int b,
                                               input int c, input int d);
        return {d[AW-1:0], c[AW-1:0], b[AW-1:0], a[AW-1:0]};
    endfunction

    task automatic clear_model();
        for (int k = 0; k < DEPTH; k++)
            for (int b = 0; b < NB; b++)
                for (int a = 0; a < NENT; a++) m_v[k][b][a] = 0;
    endtask

    // drive one window at a falling edge, check results at the next one
    task automatic run_window(input string req, input int seed,
                              input logic [VEC*BW-1:0] banks,
                              input logic [VEC*AW-1:0] addrs,
                              input logic [POS_W-1:0] pos);
        logic [VEC-1:0] e_hit;
        logic [SW-1:0]    e_s [DEPTH][VEC];
        logic [POS_W-1:0] e_p [DEPTH][VEC];
        bit               e_v [DEPTH][VEC];
        for (int i = 0; i < VEC; i++) in_str[i*SW +: SW] = mk(seed, i);
        in_bank = banks; in_addr = addrs; in_pos = pos; in_valid = 1'b1;
        for (int i = 0; i < VEC; i++) begin
            e_hit[i] = 1'b1;
            for (int j = 0; j < i; j++)
                if (banks[j*BW +: BW] == banks[i*BW +: BW]) e_hit[i] = 1'b0;
        end
        for (int i = 0; i < VEC; i++)
            for (int k = 0; k < DEPTH; k++) begin
                int b = int'(banks[i*BW +: BW]);
                int a = int'(addrs[i*AW +: AW]);
                e_v[k][i] = e_hit[i] && m_v[k][b][a];
                e_s[k][i] = e_hit[i] ? m_str[k][b][a] : '0;
                e_p[k][i] = e_hit[i] ? m_pos[k][b][a] : '0;
            end
        for (int i = 0; i < VEC; i++)
            if (e_hit[i]) begin
                int b = int'(banks[i*BW +: BW]);
                int a = int'(addrs[i*AW +: AW]);
                for (int k = DEPTH - 1; k > 0; k--) begin
                    m_str[k][b][a] = m_str[k-1][b][a];
                    m_pos[k][b][a] = m_pos[k-1][b][a];
                    m_v[k][b][a]   = m_v[k-1][b][a];
                end
                m_str[0][b][a] = mk(seed, i);
                m_pos[0][b][a] = pos + POS_W'(i);
                m_v[0][b][a]   = 1;
            end
        @(posedge clk);
        @(negedge clk);
        check("R3", "out_valid", 128'(out_valid), 128'(1));
        check("R3", "out_str", 128'(out_str), 128'(in_str));
        check("R3", "out_pos", 128'(out_pos), 128'(pos));
        check(req, "out_hit", 128'(out_hit), 128'(e_hit));
        for (int k = 0; k < DEPTH; k++)
            for (int i = 0; i < VEC; i++) begin
                check(req, $sformatf("cand_vld d%0d s%0d", k, i),
                      128'(cand_vld[k*VEC+i]), 128'(e_v[k][i]));
                if (e_v[k][i] || !e_hit[i]) begin
                    check(req, $sformatf("cand_str d%0d s%0d", k, i),
                          128'(cand_str[(k*VEC+i)*SW +: SW]), 128'(e_s[k][i]));
                    check(req, $sformatf("cand_pos d%0d s%0d", k, i),
                          128'(cand_pos[(k*VEC+i)*POS_W +: POS_W]), 128'(e_p[k][i]));
                end
            end
    endtask

    // idle cycle with live-looking inputs; nothing may be written
    task automatic run_idle(input string req);
        in_valid = 1'b0;
        in_bank = pk_b(3, 1, 2, 0);
        in_addr = pk_a(1, 1, 1, 1);
        @(posedge clk);
        @(negedge clk);
        check(req, "idle out_valid", 128'(out_valid), 128'(0));
        check(req, "idle out_hit", 128'(out_hit), 128'(0));
    endtask

    task automatic t_reset_r6();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6", "reset out_valid", 128'(out_valid), 128'(0));
        check("R6", "reset out_hit", 128'(out_hit), 128'(0));
        clear_model();
        rst_n = 1'b1;
    endtask

    task automatic t_spread_r1();
        run_window("R1", 1, pk_b(0, 2, 5, 7), pk_a(1, 2, 3, 4), 16'd100);
    endtask

    task automatic t_refill_r4();
        run_window("R4", 2, pk_b(0, 2, 5, 7), pk_a(1, 2, 3, 4), 16'd200);
    endtask

    task automatic t_chain_r5();
        run_window("R5", 3, pk_b(0, 2, 5, 7), pk_a(1, 2, 3, 4), 16'd300);
        run_window("R5", 4, pk_b(0, 2, 5, 7), pk_a(1, 2, 3, 4), 16'd400);
        run_window("R5", 5, pk_b(0, 2, 5, 7), pk_a(1, 2, 3, 4), 16'hFFFE);
    endtask

    task automatic t_conflict_r2();
        run_window("R2", 6, pk_b(3, 3, 3, 3), pk_a(0, 1, 2, 3), 16'd500);
        run_window("R2", 7, pk_b(4, 1, 1, 6), pk_a(5, 6, 7, 8), 16'd600);
    endtask

    task automatic t_lost_r7();
        run_window("R7", 8, pk_b(3, 1, 4, 6), pk_a(1, 7, 2, 9), 16'd700);
        run_idle("R7");
        run_window("R7", 9, pk_b(3, 1, 2, 0), pk_a(1, 1, 1, 1), 16'd800);
    endtask

    task automatic t_latency_r3();
        run_window("R3", 10, pk_b(7, 6, 5, 4), pk_a(15, 14, 13, 12), 16'd900);
        run_idle("R3");
    endtask

    task automatic t_midreset_r6();
        in_valid = 1'b0;
        t_reset_r6();
        @(negedge clk);
        run_window("R6", 11, pk_b(0, 2, 5, 7), pk_a(1, 2, 3, 4), 16'd1000);
    endtask

    initial begin
        t_reset_r6();
        @(negedge clk);
        t_spread_r1();
        t_refill_r4();
        t_chain_r5();
        t_conflict_r2();
        t_lost_r7();
        t_latency_r3();
        t_midreset_r6();
        in_valid = 1'b0;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule